// File: doc/BRIEF.md
# Clustered Banked Integer Register File

This block holds 128 integer registers as four banks of 32. Each bank belongs to one execution cluster. Each cluster has an issue slot with its own pair of read ports and one local write port. The instructions arrive already decoded: three 7-bit register indices (two sources and one destination), a write enable, write data, and a one-bit class tag that marks memory-access instructions.

A legality checker sits on every slot. It rejects an instruction whose operands leave the slot's bank, or a memory instruction whose address operand lies outside the designated address bank. A rejected instruction writes nothing and raises a sticky fault bit for its slot.

Copies between banks travel on a separate move port. Accepted moves wait in a small in-order queue. They then write through one extra write port that every bank provides. A build-time option treats all banks as one cluster, which lifts the source-bank restriction.

Top module: `clu_regfile`

## Requirements
- R1: A register index uses bits [6:5] to select the bank and bits [4:0] to select the entry. The read outputs of a slot give, combinationally, the stored value of the indexed register. A write in the same cycle is not visible on the read outputs until after the clock edge.
- R2: In the default split mode, a non-memory instruction on slot b (`iss_mem`=0) is illegal when either source index, or the destination index while `iss_wen`=1, lies outside bank b.
- R3: A memory instruction (`iss_mem`=1) is illegal only when its first source (the address) lies outside the address bank, which is bank 3 by default. Its second source (the data) may name any register. It never writes a register.
- R4: A legal non-memory instruction with `iss_wen`=1 stores `iss_wdata` into its destination at the clock edge. An illegal instruction stores nothing.
- R5: `fault` bit b is set on the clock edge after slot b issues an illegal instruction. It stays set until a cycle with `fault_ack`=1. When an acknowledge and a new fault arrive in the same cycle, the bit ends up set. All fault bits are 0 after reset.
- R6: Index 0 always reads 0. Local writes to index 0 are dropped, and so are moves to index 0.
- R7: An accepted move copies its source register into its destination register. The value copied is the one the source holds at the edge on which the move executes. Moves execute one per cycle, in the order they were accepted. The earliest a move can execute is the edge after the one that accepted it.
- R8: The move at the head of the queue may name the same register as a legal local write in the same cycle. In that case the local write is stored, and the move stays at the head and retries on the next cycle.
- R9: The move queue holds 4 entries. `mv_rdy` is 0 exactly when the queue is full. A move offered while `mv_rdy`=0 is discarded.
- R10: With the merged-cluster option set, the source-bank check is skipped. A non-memory instruction is then illegal only when it writes outside its slot's bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_vld | input | 4 | Instruction valid, one bit per slot |
| iss_mem | input | 4 | Memory-access class tag, one bit per slot |
| iss_wen | input | 4 | Destination write enable, per slot |
| iss_ra | input | 28 | First source index (address for memory class), 7 bits per slot |
| iss_rb | input | 28 | Second source index (data for memory class), 7 bits per slot |
| iss_rd | input | 28 | Destination index, 7 bits per slot |
| iss_wdata | input | 128 | Write data, 32 bits per slot |
| rd_a | output | 128 | Value of `iss_ra` register, per slot |
| rd_b | output | 128 | Value of `iss_rb` register, per slot |
| mv_vld | input | 1 | Move request |
| mv_src | input | 7 | Move source index |
| mv_dst | input | 7 | Move destination index |
| mv_rdy | output | 1 | Move queue can accept |
| fault | output | 4 | Sticky illegal-operand flag, per slot |
| fault_ack | input | 1 | Clears all fault flags |

## Verification
The assertions assume that `fault_ack` is an ordinary synchronous input and that the register indices only take defined values. They also assume that reading index 0 on slot 0 reflects the hardwired zero. The stimulus keeps to these assumptions: every input is driven to a known value on the falling edge after reset, and indices come only from `$urandom` with a fixed seed or from directed values. Entry numbers are biased toward a few low values, so index 0, queue stalls and a full queue come up often. The destination of each move is drawn from the same narrow set, which keeps local-write and move collisions frequent.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int NBANK     = 4;
  localparam int BANK_ENT  = 32;
  localparam int BSELW     = $clog2(NBANK);
  localparam int ESELW     = $clog2(BANK_ENT);
  localparam int IDXW      = BSELW + ESELW;

  function automatic logic [BSELW-1:0] bank_of(input logic [IDXW-1:0] idx);
    return idx[IDXW-1 -: BSELW];
  endfunction

  function automatic logic [ESELW-1:0] ent_of(input logic [IDXW-1:0] idx);
    return idx[ESELW-1:0];
  endfunction

  // legality of a non-memory instruction on slot `slot`
  function automatic logic alu_legal(input logic merged, input logic [BSELW-1:0] slot,
                                     input logic [IDXW-1:0] ra, input logic [IDXW-1:0] rb,
                                     input logic [IDXW-1:0] rd, input logic wen);
    logic src_ok;
    logic dst_ok;
    src_ok = merged || ((bank_of(ra) == slot) && (bank_of(rb) == slot));
    dst_ok = !wen || (bank_of(rd) == slot);
    return src_ok && dst_ok;
  endfunction

  function automatic logic mem_legal(input logic [BSELW-1:0] abank, input logic [IDXW-1:0] ra);
    return bank_of(ra) == abank;
  endfunction
endpackage

// File: rtl/crf_bank.sv
module crf_bank #(
  parameter int DW    = 32,
  parameter int ENT   = 32,
  parameter int ESELW = $clog2(ENT),
  parameter bit ZERO0 = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lw_en,
  input  logic [ESELW-1:0]   lw_ent,
  input  logic [DW-1:0]      lw_data,
  input  logic               mw_en,
  input  logic [ESELW-1:0]   mw_ent,
  input  logic [DW-1:0]      mw_data,
  output logic [ENT*DW-1:0]  q
);
  logic [DW-1:0] mem [ENT];

  for (genvar e = 0; e < ENT; e++) begin : g_ent
    if (ZERO0 && e == 0) begin : g_zero
      assign mem[e] = '0;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)
          mem[e] <= '0;
        else if (lw_en && lw_ent == ESELW'(e))
          mem[e] <= lw_data;           // local port wins
        else if (mw_en && mw_ent == ESELW'(e))
          mem[e] <= mw_data;
      end
    end
    assign q[e*DW +: DW] = mem[e];
  end
endmodule

// File: rtl/crf_slot_check.sv
module crf_slot_check import crf_pkg::*; #(
  parameter int SLOT      = 0,
  parameter int ADDR_BANK = 3,
  parameter bit MERGED    = 1'b0
) (
  input  logic            vld,
  input  logic            mem,
  input  logic            wen,
  input  logic [IDXW-1:0] ra,
  input  logic [IDXW-1:0] rb,
  input  logic [IDXW-1:0] rd,
  output logic            illegal,
  output logic            lw_en
);
  localparam logic [BSELW-1:0] SLOT_B = BSELW'(SLOT);
  localparam logic [BSELW-1:0] ABANK  = BSELW'(ADDR_BANK);

  logic legal;

  always_comb begin
    if (mem) legal = mem_legal(ABANK, ra);
    else     legal = alu_legal(MERGED, SLOT_B, ra, rb, rd, wen);
    illegal = vld && !legal;
    lw_en   = vld && legal && !mem && wen;
  end
endmodule

// File: rtl/crf_movq.sv
module crf_movq #(
  parameter int DEPTH = 4,
  parameter int W     = 14,
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic            pop,
  output logic [W-1:0]    dout,
  output logic            empty,
  output logic            full,
  output logic [CNTW-1:0] cnt
);
  logic [W-1:0]    slot_q [DEPTH];
  logic [PTRW-1:0] rp, wp;

  function automatic logic [PTRW-1:0] adv(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CNTW'(DEPTH));
  assign dout  = slot_q[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        slot_q[wp] <= din;
        wp         <= adv(wp);
      end
      if (pop) rp <= adv(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/clu_regfile.sv
module clu_regfile import crf_pkg::*; #(
  parameter int DW        = 32,
  parameter int MVQ_DEPTH = 4,
  parameter int ADDR_BANK = 3,
  parameter bit MERGED    = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NBANK-1:0]      iss_vld,
  input  logic [NBANK-1:0]      iss_mem,
  input  logic [NBANK-1:0]      iss_wen,
  input  logic [NBANK*IDXW-1:0] iss_ra,
  input  logic [NBANK*IDXW-1:0] iss_rb,
  input  logic [NBANK*IDXW-1:0] iss_rd,
  input  logic [NBANK*DW-1:0]   iss_wdata,
  output logic [NBANK*DW-1:0]   rd_a,
  output logic [NBANK*DW-1:0]   rd_b,
  input  logic                  mv_vld,
  input  logic [IDXW-1:0]       mv_src,
  input  logic [IDXW-1:0]       mv_dst,
  output logic                  mv_rdy,
  output logic [NBANK-1:0]      fault,
  input  logic                  fault_ack
);
  localparam int NREG = NBANK * BANK_ENT;
  localparam int CNTW = $clog2(MVQ_DEPTH + 1);

  logic [IDXW-1:0]        ra_s [NBANK];
  logic [IDXW-1:0]        rb_s [NBANK];
  logic [IDXW-1:0]        rd_s [NBANK];
  logic [ESELW-1:0]       lw_ent [NBANK];
  logic [BANK_ENT*DW-1:0] bank_q [NBANK];
  logic [DW-1:0]          allr [NREG];

  // named internal events
  logic [NBANK-1:0] illegal_v;
  logic [NBANK-1:0] lw_en;
  logic [NBANK-1:0] mw_en;
  logic             mv_stall;
  logic             mv_fire;
  logic             mv_push;
  logic             q_empty, q_full;
  logic [CNTW-1:0]  mv_cnt;
  logic [IDXW-1:0]  head_src, head_dst;
  logic [DW-1:0]    mv_data;

  for (genvar b = 0; b < NBANK; b++) begin : g_slot
    assign ra_s[b]   = iss_ra[b*IDXW +: IDXW];
    assign rb_s[b]   = iss_rb[b*IDXW +: IDXW];
    assign rd_s[b]   = iss_rd[b*IDXW +: IDXW];
    assign lw_ent[b] = ent_of(rd_s[b]);

    crf_slot_check #(.SLOT(b), .ADDR_BANK(ADDR_BANK), .MERGED(MERGED)) u_chk (
      .vld(iss_vld[b]), .mem(iss_mem[b]), .wen(iss_wen[b]),
      .ra(ra_s[b]), .rb(rb_s[b]), .rd(rd_s[b]),
      .illegal(illegal_v[b]), .lw_en(lw_en[b])
    );

    crf_bank #(.DW(DW), .ENT(BANK_ENT), .ESELW(ESELW), .ZERO0(b == 0)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .lw_en(lw_en[b]), .lw_ent(lw_ent[b]), .lw_data(iss_wdata[b*DW +: DW]),
      .mw_en(mw_en[b]), .mw_ent(ent_of(head_dst)), .mw_data(mv_data),
      .q(bank_q[b])
    );

    for (genvar e = 0; e < BANK_ENT; e++) begin : g_flat
      assign allr[b*BANK_ENT + e] = bank_q[b][e*DW +: DW];
    end

    assign rd_a[b*DW +: DW] = allr[ra_s[b]];
    assign rd_b[b*DW +: DW] = allr[rb_s[b]];
    assign mw_en[b]         = mv_fire && (bank_of(head_dst) == BSELW'(b));
  end

  // ordered move path
  assign mv_rdy  = !q_full;
  assign mv_push = mv_vld && !q_full;

  crf_movq #(.DEPTH(MVQ_DEPTH), .W(2*IDXW)) u_movq (
    .clk(clk), .rst_n(rst_n),
    .push(mv_push), .din({mv_src, mv_dst}),
    .pop(mv_fire), .dout({head_src, head_dst}),
    .empty(q_empty), .full(q_full), .cnt(mv_cnt)
  );

  assign mv_data = allr[head_src];

  always_comb begin
    mv_stall = 1'b0;
    for (int b = 0; b < NBANK; b++)
      if (!q_empty && lw_en[b] && rd_s[b] == head_dst) mv_stall = 1'b1;
    mv_fire = !q_empty && !mv_stall;
  end

  // sticky fault flags
  always_ff @(posedge clk) begin
    if (!rst_n) fault <= '0;
    else        fault <= (fault_ack ? '0 : fault) | illegal_v;
  end
endmodule

// File: rtl/crf_chk.sv
module crf_chk #(
  parameter int DW    = 32,
  parameter int NB    = 4,
  parameter int DEPTH = 4,
  parameter int CNTW  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NB-1:0]   fault,
  input logic            fault_ack,
  input logic [NB-1:0]   illegal_v,
  input logic            mv_rdy,
  input logic [CNTW-1:0] mv_cnt,
  input logic            mv_stall,
  input logic            mv_fire,
  input logic [6:0]      ra0,
  input logic [DW-1:0]   rda0
);
  // R5: flags hold until acknowledged
  p_fault_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_ack |=> ((fault & $past(fault)) == $past(fault)));

  // R4/R5: every illegal issue raises its flag next cycle
  p_fault_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_v != '0) |=> ((fault & $past(illegal_v)) == $past(illegal_v)));

  // R9: a full queue refuses moves
  p_full_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_cnt == CNTW'(DEPTH)) |-> !mv_rdy);

  // R8: a stalled head does not execute
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mv_stall |-> !mv_fire);

  // R6: index 0 reads zero
  p_zero_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ra0 == 7'd0) |-> (rda0 == '0));
endmodule

bind clu_regfile crf_chk #(.DW(DW), .NB(crf_pkg::NBANK), .DEPTH(MVQ_DEPTH), .CNTW(CNTW)) u_crf_chk (
  .clk(clk), .rst_n(rst_n), .fault(fault), .fault_ack(fault_ack),
  .illegal_v(illegal_v), .mv_rdy(mv_rdy), .mv_cnt(mv_cnt),
  .mv_stall(mv_stall), .mv_fire(mv_fire),
  .ra0(iss_ra[6:0]), .rda0(rd_a[DW-1:0])
);

// File: tb/test_clu_regfile.sv
module test_clu_regfile;
  localparam int NB = 4;
  localparam int DW = 32;
  localparam int AB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] iv, im, iw;
  logic [NB*7-1:0] ira, irb, ird;
  logic [NB*DW-1:0] iwd;
  logic [NB*DW-1:0] ra_o, rb_o, ra_m, rb_m;
  logic mvv, rdy_o, rdy_m, ack;
  logic [6:0] mvs, mvd;
  logic [NB-1:0] flt_o, flt_m;

  always #5 clk = ~clk;

  clu_regfile i_clu_regfile (.clk(clk), .rst_n(rst_n), .iss_vld(iv), .iss_mem(im), .iss_wen(iw),
    .iss_ra(ira), .iss_rb(irb), .iss_rd(ird), .iss_wdata(iwd), .rd_a(ra_o), .rd_b(rb_o),
    .mv_vld(mvv), .mv_src(mvs), .mv_dst(mvd), .mv_rdy(rdy_o), .fault(flt_o), .fault_ack(ack));

  clu_regfile #(.MERGED(1'b1)) i_clu_regfile_merged (.clk(clk), .rst_n(rst_n), .iss_vld(iv),
    .iss_mem(im), .iss_wen(iw), .iss_ra(ira), .iss_rb(irb), .iss_rd(ird), .iss_wdata(iwd),
    .rd_a(ra_m), .rd_b(rb_m), .mv_vld(1'b0), .mv_src(mvs), .mv_dst(mvd), .mv_rdy(rdy_m),
    .fault(flt_m), .fault_ack(ack));

  // reference state
  logic [DW-1:0] mr [128];
  logic [6:0] qs [4];
  logic [6:0] qd [4];
  int qn;
  logic [NB-1:0] fs, fm;
  int nchk = 0, nfail = 0;
  string tag = "R1";

  task automatic check(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  function automatic bit legal(input bit merged, input int b, input bit mem, input bit wen,
                               input logic [6:0] a, input logic [6:0] s, input logic [6:0] d);
    if (mem) return (a / 32) == AB;
    if (wen && (d / 32) != b) return 0;
    if (merged) return 1;
    return ((a / 32) == b) && ((s / 32) == b);
  endfunction

  task automatic clr();
    iv = '0; im = '0; iw = '0; ira = '0; irb = '0; ird = '0; iwd = '0;
    mvv = 1'b0; mvs = '0; mvd = '0; ack = 1'b0;
  endtask

  task automatic put(input int b, input bit mem, input bit wen, input logic [6:0] a,
                     input logic [6:0] s, input logic [6:0] d, input logic [DW-1:0] w);
    iv[b] = 1'b1; im[b] = mem; iw[b] = wen;
    ira[b*7 +: 7] = a; irb[b*7 +: 7] = s; ird[b*7 +: 7] = d; iwd[b*DW +: DW] = w;
  endtask

  task automatic step();
    logic [DW-1:0] nr [128];
    logic [NB-1:0] ill_s, ill_m;
    bit conf;
    #1;
    for (int b = 0; b < NB; b++) begin
      logic [6:0] a = ira[b*7 +: 7];
      logic [6:0] s = irb[b*7 +: 7];
      check(ra_o[b*DW +: DW] == mr[a], (a == 0) ? "R6" : tag, ra_o[b*DW +: DW], mr[a]);
      check(rb_o[b*DW +: DW] == mr[s], tag, rb_o[b*DW +: DW], mr[s]);
    end
    check(rdy_o == (qn < 4), "R9", rdy_o, qn < 4);
    check(flt_o == fs, "R5", flt_o, fs);
    check(flt_m == fm, "R10", flt_m, fm);
    for (int i = 0; i < 128; i++) nr[i] = mr[i];
    conf = 0;
    for (int b = 0; b < NB; b++) begin
      logic [6:0] a = ira[b*7 +: 7];
      logic [6:0] s = irb[b*7 +: 7];
      logic [6:0] d = ird[b*7 +: 7];
      ill_s[b] = iv[b] && !legal(0, b, im[b], iw[b], a, s, d);
      ill_m[b] = iv[b] && !legal(1, b, im[b], iw[b], a, s, d);
      if (iv[b] && !ill_s[b] && !im[b] && iw[b]) begin
        if (d != 0) nr[d] = iwd[b*DW +: DW];
        if (qn > 0 && d == qd[0]) conf = 1;
      end
    end
    if (qn > 0 && !conf) begin
      if (qd[0] != 0) nr[qd[0]] = mr[qs[0]];
      for (int i = 0; i < 3; i++) begin qs[i] = qs[i+1]; qd[i] = qd[i+1]; end
      qn--;
    end
    if (mvv && rdy_o == 1'b1 && qn < 4) begin qs[qn] = mvs; qd[qn] = mvd; qn++; end
    @(posedge clk);
    for (int i = 0; i < 128; i++) mr[i] = nr[i];
    fs = (ack ? '0 : fs) | ill_s;
    fm = (ack ? '0 : fm) | ill_m;
    @(negedge clk);
  endtask

  function automatic logic [6:0] pick(input int bank);
    return 7'(bank * 32 + ($urandom % 8));
  endfunction

  initial begin
    #(200000 * 10);
    nfail++; nchk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 128; i++) mr[i] = '0;
    qn = 0; fs = '0; fm = '0;
    clr();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // reset state (R5, R9, R1)
    check(flt_o == '0, "R5", flt_o, 0);
    check(rdy_o == 1'b1, "R9", rdy_o, 1);
    check(ra_o == '0, "R1", ra_o, 0);

    // R6: write to index 0 dropped
    tag = "R6"; clr(); put(0, 0, 1, 7'd1, 7'd2, 7'd0, 32'hFFFF_FFFF); step();
    clr(); put(0, 0, 0, 7'd0, 7'd0, 7'd0, 0); step();

    // R4: legal write lands, R2: spanning instruction faults and writes nothing
    tag = "R4"; clr(); put(1, 0, 1, 7'd33, 7'd34, 7'd40, 32'hA5A5_0001); step();
    tag = "R2"; clr(); put(1, 0, 1, 7'd33, 7'd66, 7'd40, 32'h1234_5678); step();
    clr(); put(1, 0, 0, 7'd40, 7'd40, 7'd0, 0); step();
    check(ra_o[1*DW +: DW] == 32'hA5A5_0001, "R2", ra_o[1*DW +: DW], 32'hA5A5_0001);

    // R3: memory class, data from any bank, address bank enforced, no write
    tag = "R3"; clr(); put(2, 1, 1, 7'd100, 7'd40, 7'd70, 32'hDEAD_0000); step();
    clr(); put(2, 1, 0, 7'd10, 7'd40, 7'd70, 0); step();
    clr(); put(2, 0, 0, 7'd70, 7'd70, 7'd70, 0); step();
    check(ra_o[2*DW +: DW] == '0, "R3", ra_o[2*DW +: DW], 0);

    // R5: acknowledge together with a new fault keeps the flag
    tag = "R5"; clr(); ack = 1; put(1, 0, 0, 7'd5, 7'd33, 7'd0, 0); step();
    clr(); ack = 1; step();
    clr(); step();
    check(flt_o == '0, "R5", flt_o, 0);

    // R7: value into bank2 then two ordered moves to the same destination
    tag = "R7"; clr(); put(2, 0, 1, 7'd64, 7'd64, 7'd65, 32'h0000_0BB1); put(3, 0, 1, 7'd96, 7'd96, 7'd97, 32'h0000_0CC2); step();
    clr(); mvv = 1; mvs = 7'd65; mvd = 7'd38; step();
    clr(); mvv = 1; mvs = 7'd97; mvd = 7'd38; step();
    clr(); step(); clr(); step();
    check(mr[38] == 32'h0000_0CC2, "R7", mr[38], 32'h0CC2);

    // R8/R9: keep the head blocked by local writes until the queue is full
    tag = "R8";
    for (int k = 0; k < 7; k++) begin
      clr(); put(1, 0, 1, 7'd33, 7'd33, 7'd38, 32'h100 + k);
      mvv = 1; mvs = 7'(64 + k); mvd = 7'd38;
      step();
    end
    check(rdy_o == 1'b0, "R9", rdy_o, 0);
    tag = "R9";
    for (int k = 0; k < 6; k++) begin clr(); step(); end

    // constrained random
    tag = "R1";
    for (int n = 0; n < 3000; n++) begin
      clr();
      for (int b = 0; b < NB; b++) begin
        if ($urandom % 4 != 0) begin
          bit mem = ($urandom % 4 == 0);
          int ab = mem ? AB : b;
          if ($urandom % 8 == 0) ab = $urandom % 4;
          put(b, mem, $urandom % 2,
              pick(ab),
              pick(($urandom % 8 == 0 || mem) ? ($urandom % 4) : b),
              pick(($urandom % 10 == 0) ? ($urandom % 4) : b),
              $urandom);
        end
      end
      mvv = ($urandom % 2);
      mvs = 7'($urandom % 128);
      mvd = pick($urandom % 4);
      ack = ($urandom % 8 == 0);
      step();
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule